// File: doc/BRIEF.md
# Register Scoreboard Wakeup Unit

This unit sits beside an instruction queue and decides when each queued instruction has all of its operands. It holds one ready bit per physical register and, for each register, a bit vector naming the queue entries whose first or second source waits on it. Rename and select logic stay outside: the unit is told when an instruction is written into a queue slot, when a result register is broadcast as complete, and when entries leave the queue, either by squash or by release after issue.

When an instruction is inserted, the unit marks its destination register as not ready. Each source that is not already flagged ready is checked against the scoreboard, including a completion that is being applied on the same edge. Any source that is still outstanding sets a bit in that register's waiter vector. A completion broadcast is registered and applied one cycle later. When it is applied, it sets the scoreboard bit, marks ready the matching sources of every waiter, and empties the waiter vector. Register indices past the physical range, used for control and miscellaneous state, bypass the whole mechanism.

Each slot raises a per-entry ready flag when it holds an instruction, both of its sources are ready, and it is not held back as non-speculative. Inserting a producer while its destination register still has waiters is reported as an error on a combinational flag.

Top module: `sbw_wakeup_unit`

## Requirements
- R1: After reset, every physical register reads ready, and no slot is busy or ready.
- R2: Inserting an instruction whose destination is valid and below NUM_PREGS clears that register's bit in `preg_rdy_o` from the next cycle.
- R3: A valid source at insert is ready at once if it is flagged ready or the scoreboard shows its register ready. Otherwise it waits.
- R4: A completion presented in cycle N is applied at the end of cycle N+1. From then on the register reads ready and every waiting source on it is ready. An insert on that applying edge already sees the register as ready.
- R5: Register indices at or above NUM_PREGS never block a source. A completion or a destination with such an index leaves the scoreboard unchanged.
- R6: `chain_err_o` is high while an insert presents a tracked destination that still has waiting sources, unless a completion for that register is being applied on the same edge.
- R7: A set bit in `sq_mask_i` frees that slot on the next edge and removes it from all waiter vectors. A later completion of its old source does not wake a new occupant, and the squashed entry no longer counts as a waiter for R6.
- R8: `ready_o[i]` is high exactly when slot i is busy, both sources are ready, and the slot is not blocked as non-speculative. A non-speculative release for the slot lifts the block.
- R9: A release for a slot clears its busy flag on the next edge.
- R10: On the same edge, an insert into a slot wins over a squash or release of that slot. An insert that clears a register wins over a completion setting it.
- R11: When both sources of an entry name the same unready register, one completion readies both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ins_valid_i | input | 1 | Insert an instruction this cycle |
| ins_slot_i | input | SLOT_W | Queue slot written |
| ins_src0_i | input | REG_W | First source register |
| ins_src0_vld_i | input | 1 | First source is used |
| ins_src0_rdy_i | input | 1 | First source already known ready |
| ins_src1_i | input | REG_W | Second source register |
| ins_src1_vld_i | input | 1 | Second source is used |
| ins_src1_rdy_i | input | 1 | Second source already known ready |
| ins_dst_i | input | REG_W | Destination register |
| ins_dst_vld_i | input | 1 | Destination is written |
| ins_nonspec_i | input | 1 | Hold the entry until a non-speculative release |
| cmp_valid_i | input | 1 | Completion broadcast |
| cmp_reg_i | input | REG_W | Completed destination register |
| sq_mask_i | input | NUM_ENTRIES | Slots squashed this cycle |
| rel_valid_i | input | 1 | Release a slot after issue |
| rel_slot_i | input | SLOT_W | Slot released |
| nsr_valid_i | input | 1 | Lift the non-speculative block of a slot |
| nsr_slot_i | input | SLOT_W | Slot whose block is lifted |
| busy_o | output | NUM_ENTRIES | Slot holds an instruction |
| ready_o | output | NUM_ENTRIES | Slot may be selected for issue |
| preg_rdy_o | output | NUM_PREGS | Scoreboard ready bits |
| chain_err_o | output | 1 | Producer inserted onto a register with waiters |

## Verification
The checker watches, on every cycle, that only busy slots are ready, that an inserted destination reads not ready after the edge, and that an applied completion reads ready unless an insert overrode it. It also checks that untracked sources never hold a slot back and that squashed slots are free on the next edge. The waiter bookkeeping can only be shown by the bench scenarios. These cover the same-edge bypass at insert, a squashed entry that must not be woken or counted for the chain error, the doubled source, and the precedence of insert over squash and completion. A behavioural model of entries and registers compares every output on each cycle.

// File: rtl/sbw_pkg.sv
`timescale 1ns/1ps
package sbw_pkg;
  localparam int unsigned NUM_SRC = 2;

  function automatic logic in_range(input int unsigned idx, input int unsigned lim);
    return idx < lim;
  endfunction
endpackage

// File: rtl/sbw_scoreboard.sv
`timescale 1ns/1ps
module sbw_scoreboard #(
  parameter int unsigned NUM_PREGS = 16,
  parameter int unsigned REG_W     = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_vld_i,
  input  logic [REG_W-1:0]     set_reg_i,
  input  logic                 clr_vld_i,
  input  logic [REG_W-1:0]     clr_reg_i,
  output logic [NUM_PREGS-1:0] rdy_o
);
  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_bit
    logic set_here, clr_here;
    assign set_here = set_vld_i && (set_reg_i == REG_W'(r));
    assign clr_here = clr_vld_i && (clr_reg_i == REG_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdy_o[r] <= 1'b1;
      else if (clr_here) rdy_o[r] <= 1'b0;  // new producer wins
      else if (set_here) rdy_o[r] <= 1'b1;
    end
  end
endmodule

// File: rtl/sbw_waiters.sv
`timescale 1ns/1ps
module sbw_waiters #(
  parameter int unsigned NUM_PREGS   = 16,
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned REG_W       = 5,
  localparam int unsigned SLOT_W     = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   add_vld_i,
  input  logic [REG_W-1:0]       add_reg_i,
  input  logic [SLOT_W-1:0]      add_slot_i,
  input  logic                   wake_vld_i,
  input  logic [REG_W-1:0]       wake_reg_i,
  input  logic [NUM_ENTRIES-1:0] clr_col_i,
  output logic [NUM_ENTRIES-1:0] hit_o,
  output logic [NUM_PREGS-1:0]   row_busy_o
);
  logic [NUM_PREGS-1:0][NUM_ENTRIES-1:0] w_q;
  logic [NUM_ENTRIES-1:0] add_oh;

  assign add_oh = NUM_ENTRIES'(1) << add_slot_i;

  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_row
    logic wake_here, add_here;
    assign wake_here = wake_vld_i && (wake_reg_i == REG_W'(r));
    assign add_here  = add_vld_i  && (add_reg_i  == REG_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) w_q[r] <= '0;
      else         w_q[r] <= (w_q[r] & ~clr_col_i & ~{NUM_ENTRIES{wake_here}})
                           | (add_here ? add_oh : '0);
    end
    assign row_busy_o[r] = |w_q[r];
  end

  always_comb begin
    hit_o = '0;
    for (int r = 0; r < NUM_PREGS; r++)
      if (wake_vld_i && (wake_reg_i == REG_W'(r))) hit_o = w_q[r];
  end
endmodule

// File: rtl/sbw_entries.sv
`timescale 1ns/1ps
module sbw_entries
  import sbw_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned SLOT_W     = $clog2(NUM_ENTRIES)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  ins_vld_i,
  input  logic [SLOT_W-1:0]                     ins_slot_i,
  input  logic [NUM_SRC-1:0]                    ins_src_ok_i,
  input  logic                                  ins_ns_i,
  input  logic [NUM_SRC-1:0][NUM_ENTRIES-1:0]   hit_i,
  input  logic [NUM_ENTRIES-1:0]                free_i,
  input  logic                                  nsr_vld_i,
  input  logic [SLOT_W-1:0]                     nsr_slot_i,
  output logic [NUM_ENTRIES-1:0]                busy_o,
  output logic [NUM_ENTRIES-1:0]                ready_o
);
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic [NUM_SRC-1:0] rdy_q;
    logic               ns_q;
    logic               ins_here;
    logic [NUM_SRC-1:0] hit_e;

    assign ins_here = ins_vld_i && (ins_slot_i == SLOT_W'(e));
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_hit
      assign hit_e[k] = hit_i[k][e];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_o[e] <= 1'b0;
        rdy_q     <= '0;
        ns_q      <= 1'b0;
      end else if (ins_here) begin
        busy_o[e] <= 1'b1;
        rdy_q     <= ins_src_ok_i;
        ns_q      <= ins_ns_i;
      end else begin
        if (free_i[e]) busy_o[e] <= 1'b0;
        rdy_q <= rdy_q | hit_e;
        if (nsr_vld_i && (nsr_slot_i == SLOT_W'(e))) ns_q <= 1'b0;
      end
    end

    assign ready_o[e] = busy_o[e] && (&rdy_q) && !ns_q;
  end
endmodule

// File: rtl/sbw_wakeup_unit.sv
`timescale 1ns/1ps
module sbw_wakeup_unit
  import sbw_pkg::*;
#(
  parameter int unsigned NUM_PREGS   = 16,
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned REG_W       = 5,
  localparam int unsigned SLOT_W     = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ins_valid_i,
  input  logic [SLOT_W-1:0]      ins_slot_i,
  input  logic [REG_W-1:0]       ins_src0_i,
  input  logic                   ins_src0_vld_i,
  input  logic                   ins_src0_rdy_i,
  input  logic [REG_W-1:0]       ins_src1_i,
  input  logic                   ins_src1_vld_i,
  input  logic                   ins_src1_rdy_i,
  input  logic [REG_W-1:0]       ins_dst_i,
  input  logic                   ins_dst_vld_i,
  input  logic                   ins_nonspec_i,
  input  logic                   cmp_valid_i,
  input  logic [REG_W-1:0]       cmp_reg_i,
  input  logic [NUM_ENTRIES-1:0] sq_mask_i,
  input  logic                   rel_valid_i,
  input  logic [SLOT_W-1:0]      rel_slot_i,
  input  logic                   nsr_valid_i,
  input  logic [SLOT_W-1:0]      nsr_slot_i,
  output logic [NUM_ENTRIES-1:0] busy_o,
  output logic [NUM_ENTRIES-1:0] ready_o,
  output logic [NUM_PREGS-1:0]   preg_rdy_o,
  output logic                   chain_err_o
);
  logic [NUM_SRC-1:0][REG_W-1:0]       src;
  logic [NUM_SRC-1:0]                  src_vld, src_flag, src_ok, add_vld;
  logic [NUM_SRC-1:0][NUM_ENTRIES-1:0] hit;
  logic [NUM_SRC-1:0][NUM_PREGS-1:0]   row_busy;
  logic [NUM_ENTRIES-1:0]              ins_oh, rel_oh, free_col, clr_col;
  logic                                cmp_q_vld, cmp_apply, dst_busy;
  logic [REG_W-1:0]                    cmp_q_reg;

  assign src      = {ins_src1_i, ins_src0_i};
  assign src_vld  = {ins_src1_vld_i, ins_src0_vld_i};
  assign src_flag = {ins_src1_rdy_i, ins_src0_rdy_i};

  // completion takes effect one cycle after it is presented
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q_vld <= 1'b0;
      cmp_q_reg <= '0;
    end else begin
      cmp_q_vld <= cmp_valid_i;
      cmp_q_reg <= cmp_reg_i;
    end
  end
  assign cmp_apply = cmp_q_vld && in_range(32'(cmp_q_reg), NUM_PREGS);

  assign ins_oh   = ins_valid_i ? (NUM_ENTRIES'(1) << ins_slot_i) : '0;
  assign rel_oh   = rel_valid_i ? (NUM_ENTRIES'(1) << rel_slot_i) : '0;
  assign free_col = sq_mask_i | rel_oh;
  assign clr_col  = free_col | ins_oh;

  // source check at insert, with bypass of the completion applied this edge
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic trk, sb_hit;
    assign trk = in_range(32'(src[k]), NUM_PREGS);
    always_comb begin
      sb_hit = 1'b0;
      for (int r = 0; r < NUM_PREGS; r++)
        if (src[k] == REG_W'(r)) sb_hit = preg_rdy_o[r];
    end
    assign src_ok[k]  = !src_vld[k] || !trk || src_flag[k] || sb_hit
                      || (cmp_apply && (cmp_q_reg == src[k]));
    assign add_vld[k] = ins_valid_i && !src_ok[k];

    sbw_waiters #(
      .NUM_PREGS  (NUM_PREGS),
      .NUM_ENTRIES(NUM_ENTRIES),
      .REG_W      (REG_W)
    ) u_wait (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .add_vld_i  (add_vld[k]),
      .add_reg_i  (src[k]),
      .add_slot_i (ins_slot_i),
      .wake_vld_i (cmp_apply),
      .wake_reg_i (cmp_q_reg),
      .clr_col_i  (clr_col),
      .hit_o      (hit[k]),
      .row_busy_o (row_busy[k])
    );
  end

  sbw_scoreboard #(
    .NUM_PREGS(NUM_PREGS),
    .REG_W    (REG_W)
  ) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_vld_i (cmp_apply),
    .set_reg_i (cmp_q_reg),
    .clr_vld_i (ins_valid_i && ins_dst_vld_i),
    .clr_reg_i (ins_dst_i),
    .rdy_o     (preg_rdy_o)
  );

  sbw_entries #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_ent (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ins_vld_i    (ins_valid_i),
    .ins_slot_i   (ins_slot_i),
    .ins_src_ok_i (src_ok),
    .ins_ns_i     (ins_nonspec_i),
    .hit_i        (hit),
    .free_i       (free_col),
    .nsr_vld_i    (nsr_valid_i),
    .nsr_slot_i   (nsr_slot_i),
    .busy_o       (busy_o),
    .ready_o      (ready_o)
  );

  // producer onto a register that still has waiters
  always_comb begin
    dst_busy = 1'b0;
    for (int r = 0; r < NUM_PREGS; r++)
      if (ins_dst_i == REG_W'(r)) dst_busy = row_busy[0][r] || row_busy[1][r];
  end
  assign chain_err_o = ins_valid_i && ins_dst_vld_i && dst_busy
                    && !(cmp_apply && (cmp_q_reg == ins_dst_i));
endmodule

// File: rtl/sbw_wakeup_chk.sv
`timescale 1ns/1ps
module sbw_wakeup_chk #(
  parameter int unsigned NUM_PREGS   = 16,
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned REG_W       = 5,
  localparam int unsigned SLOT_W     = $clog2(NUM_ENTRIES),
  localparam int unsigned IDX_W      = $clog2(NUM_PREGS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   ins_valid_i,
  input logic [SLOT_W-1:0]      ins_slot_i,
  input logic [REG_W-1:0]       ins_src0_i,
  input logic                   ins_src0_vld_i,
  input logic [REG_W-1:0]       ins_src1_i,
  input logic                   ins_src1_vld_i,
  input logic [REG_W-1:0]       ins_dst_i,
  input logic                   ins_dst_vld_i,
  input logic                   ins_nonspec_i,
  input logic                   cmp_valid_i,
  input logic [REG_W-1:0]       cmp_reg_i,
  input logic [NUM_ENTRIES-1:0] sq_mask_i,
  input logic [NUM_ENTRIES-1:0] busy_o,
  input logic [NUM_ENTRIES-1:0] ready_o,
  input logic [NUM_PREGS-1:0]   preg_rdy_o
);
  logic trk_dst, trk_cmp, free0, free1;
  logic dst_q, c1_q, c2_q, u_q;
  logic [IDX_W-1:0]       dst_idx_q, c1_idx_q, c2_idx_q;
  logic [SLOT_W-1:0]      u_slot_q;
  logic [NUM_ENTRIES-1:0] sq_q, ins_oh;

  assign trk_dst = {1'b0, ins_dst_i} < (REG_W+1)'(NUM_PREGS);
  assign trk_cmp = {1'b0, cmp_reg_i} < (REG_W+1)'(NUM_PREGS);
  assign free0   = !ins_src0_vld_i || ({1'b0, ins_src0_i} >= (REG_W+1)'(NUM_PREGS));
  assign free1   = !ins_src1_vld_i || ({1'b0, ins_src1_i} >= (REG_W+1)'(NUM_PREGS));
  assign ins_oh  = ins_valid_i ? (NUM_ENTRIES'(1) << ins_slot_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= 1'b0; c1_q <= 1'b0; c2_q <= 1'b0; u_q <= 1'b0;
      dst_idx_q <= '0; c1_idx_q <= '0; c2_idx_q <= '0; u_slot_q <= '0;
      sq_q <= '0;
    end else begin
      dst_q     <= ins_valid_i && ins_dst_vld_i && trk_dst;
      dst_idx_q <= ins_dst_i[IDX_W-1:0];
      c1_q      <= cmp_valid_i && trk_cmp;
      c1_idx_q  <= cmp_reg_i[IDX_W-1:0];
      c2_q      <= c1_q && !(ins_valid_i && ins_dst_vld_i && trk_dst
                             && (ins_dst_i[IDX_W-1:0] == c1_idx_q));
      c2_idx_q  <= c1_idx_q;
      u_q       <= ins_valid_i && !ins_nonspec_i && free0 && free1;
      u_slot_q  <= ins_slot_i;
      sq_q      <= sq_mask_i & ~ins_oh;
    end
  end

  // R8
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o & ~busy_o) == '0);
  // R2
  dst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_q |-> !preg_rdy_o[dst_idx_q]);
  // R4
  cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c2_q |-> preg_rdy_o[c2_idx_q]);
  // R5
  untracked_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    u_q |-> ready_o[u_slot_q]);
  // R7
  squash_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_q & busy_o) == '0);
endmodule

bind sbw_wakeup_unit sbw_wakeup_chk #(
  .NUM_PREGS  (NUM_PREGS),
  .NUM_ENTRIES(NUM_ENTRIES),
  .REG_W      (REG_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ins_valid_i    (ins_valid_i),
  .ins_slot_i     (ins_slot_i),
  .ins_src0_i     (ins_src0_i),
  .ins_src0_vld_i (ins_src0_vld_i),
  .ins_src1_i     (ins_src1_i),
  .ins_src1_vld_i (ins_src1_vld_i),
  .ins_dst_i      (ins_dst_i),
  .ins_dst_vld_i  (ins_dst_vld_i),
  .ins_nonspec_i  (ins_nonspec_i),
  .cmp_valid_i    (cmp_valid_i),
  .cmp_reg_i      (cmp_reg_i),
  .sq_mask_i      (sq_mask_i),
  .busy_o         (busy_o),
  .ready_o        (ready_o),
  .preg_rdy_o     (preg_rdy_o)
);

// File: tb/sbw_wakeup_unit_test.sv
`timescale 1ns/1ps
module sbw_wakeup_unit_test;
  localparam int NP = 16;
  localparam int NE = 8;
  localparam int RW = 5;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ins_valid_i, ins_src0_vld_i, ins_src0_rdy_i, ins_src1_vld_i, ins_src1_rdy_i;
  logic ins_dst_vld_i, ins_nonspec_i, cmp_valid_i, rel_valid_i, nsr_valid_i;
  logic [SW-1:0] ins_slot_i, rel_slot_i, nsr_slot_i;
  logic [RW-1:0] ins_src0_i, ins_src1_i, ins_dst_i, cmp_reg_i;
  logic [NE-1:0] sq_mask_i, busy_o, ready_o;
  logic [NP-1:0] preg_rdy_o;
  logic chain_err_o;

  always #2.5 clk = ~clk;

  sbw_wakeup_unit #(.NUM_PREGS(NP), .NUM_ENTRIES(NE), .REG_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ins_valid_i(ins_valid_i), .ins_slot_i(ins_slot_i),
    .ins_src0_i(ins_src0_i), .ins_src0_vld_i(ins_src0_vld_i), .ins_src0_rdy_i(ins_src0_rdy_i),
    .ins_src1_i(ins_src1_i), .ins_src1_vld_i(ins_src1_vld_i), .ins_src1_rdy_i(ins_src1_rdy_i),
    .ins_dst_i(ins_dst_i), .ins_dst_vld_i(ins_dst_vld_i), .ins_nonspec_i(ins_nonspec_i),
    .cmp_valid_i(cmp_valid_i), .cmp_reg_i(cmp_reg_i), .sq_mask_i(sq_mask_i),
    .rel_valid_i(rel_valid_i), .rel_slot_i(rel_slot_i),
    .nsr_valid_i(nsr_valid_i), .nsr_slot_i(nsr_slot_i),
    .busy_o(busy_o), .ready_o(ready_o), .preg_rdy_o(preg_rdy_o), .chain_err_o(chain_err_o));

  // behavioural reference
  bit m_sb[NP];
  bit m_v[NE];
  bit m_ns[NE];
  int m_src[NE][2];
  bit m_rdy[NE][2];
  bit m_cv;
  int m_cr;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NP; r++) m_sb[r] = 1;
    for (int e = 0; e < NE; e++) begin
      m_v[e] = 0; m_ns[e] = 0;
      for (int k = 0; k < 2; k++) begin m_rdy[e][k] = 0; m_src[e][k] = 0; end
    end
    m_cv = 0; m_cr = 0;
  endtask

  task automatic compare();
    logic [NE-1:0] eb, er;
    logic [NP-1:0] ep;
    logic ee;
    int d;
    for (int e = 0; e < NE; e++) begin
      eb[e] = m_v[e];
      er[e] = m_v[e] && m_rdy[e][0] && m_rdy[e][1] && !m_ns[e];
    end
    for (int r = 0; r < NP; r++) ep[r] = m_sb[r];
    d = int'(ins_dst_i);
    ee = 0;
    if (ins_valid_i && ins_dst_vld_i && d < NP && !(m_cv && m_cr == d))
      for (int e = 0; e < NE; e++)
        for (int k = 0; k < 2; k++)
          if (m_v[e] && !m_rdy[e][k] && m_src[e][k] == d) ee = 1;
    chk(cur_req, "busy", 32'(busy_o), 32'(eb));
    chk(cur_req, "ready", 32'(ready_o), 32'(er));
    chk(cur_req, "preg", 32'(preg_rdy_o), 32'(ep));
    chk(cur_req, "chain_err", 32'(chain_err_o), 32'(ee));
  endtask

  task automatic model_step();
    int s[2];
    bit v[2], f[2];
    if (m_cv && m_cr < NP) begin
      m_sb[m_cr] = 1;
      for (int e = 0; e < NE; e++)
        for (int k = 0; k < 2; k++)
          if (m_v[e] && !m_rdy[e][k] && m_src[e][k] == m_cr) m_rdy[e][k] = 1;
    end
    for (int e = 0; e < NE; e++) if (sq_mask_i[e]) m_v[e] = 0;
    if (rel_valid_i) m_v[rel_slot_i] = 0;
    if (nsr_valid_i) m_ns[nsr_slot_i] = 0;
    if (ins_valid_i) begin
      s[0] = int'(ins_src0_i); v[0] = ins_src0_vld_i; f[0] = ins_src0_rdy_i;
      s[1] = int'(ins_src1_i); v[1] = ins_src1_vld_i; f[1] = ins_src1_rdy_i;
      m_v[ins_slot_i] = 1;
      m_ns[ins_slot_i] = ins_nonspec_i;
      for (int k = 0; k < 2; k++) begin
        m_src[ins_slot_i][k] = s[k];
        m_rdy[ins_slot_i][k] = !v[k] || s[k] >= NP || f[k] || m_sb[s[k]];
      end
      if (ins_dst_vld_i && int'(ins_dst_i) < NP) m_sb[ins_dst_i] = 0;
    end
    m_cv = cmp_valid_i;
    m_cr = int'(cmp_reg_i);
  endtask

  task automatic idle();
    ins_valid_i = 0; ins_slot_i = '0; ins_src0_i = '0; ins_src0_vld_i = 0; ins_src0_rdy_i = 0;
    ins_src1_i = '0; ins_src1_vld_i = 0; ins_src1_rdy_i = 0; ins_dst_i = '0; ins_dst_vld_i = 0;
    ins_nonspec_i = 0; cmp_valid_i = 0; cmp_reg_i = '0; sq_mask_i = '0;
    rel_valid_i = 0; rel_slot_i = '0; nsr_valid_i = 0; nsr_slot_i = '0;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
  endtask

  task automatic ins(int slot, int s0, bit v0, bit f0, int s1, bit v1, bit f1, int d, bit dv, bit ns);
    ins_valid_i = 1; ins_slot_i = SW'(slot);
    ins_src0_i = RW'(s0); ins_src0_vld_i = v0; ins_src0_rdy_i = f0;
    ins_src1_i = RW'(s1); ins_src1_vld_i = v1; ins_src1_rdy_i = f1;
    ins_dst_i = RW'(d); ins_dst_vld_i = dv; ins_nonspec_i = ns;
  endtask

  task automatic cmp(int r);
    cmp_valid_i = 1; cmp_reg_i = RW'(r);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    cur_req = "R1";
    chk("R1", "preg after reset", 32'(preg_rdy_o), 32'({NP{1'b1}}));
    chk("R1", "busy after reset", 32'(busy_o), 32'h0);
    tick();

    // R2 / R3
    cur_req = "R2";
    ins(0, 0, 0, 0, 0, 0, 0, 3, 1, 0); tick();
    chk("R2", "preg3 cleared", 32'(preg_rdy_o[3]), 32'h0);
    cur_req = "R3";
    ins(1, 3, 1, 0, 4, 1, 0, 10, 1, 0); tick();
    ins(2, 3, 1, 1, 0, 0, 0, 0, 0, 0); tick();
    chk("R3", "flagged source ready", 32'(ready_o[2]), 32'h1);
    chk("R3", "waiting source", 32'(ready_o[1]), 32'h0);

    // R4 completion latency and bypass
    cur_req = "R4";
    cmp(3); tick();
    chk("R4", "not yet applied", 32'(ready_o[1]), 32'h0);
    tick();
    chk("R4", "waiter woken", 32'(ready_o[1]), 32'h1);
    chk("R4", "preg3 set", 32'(preg_rdy_o[3]), 32'h1);
    ins(3, 0, 0, 0, 0, 0, 0, 5, 1, 0); tick();
    cmp(5); tick();
    ins(4, 5, 1, 0, 0, 0, 0, 0, 0, 0); tick();
    chk("R4", "bypass at insert", 32'(ready_o[4]), 32'h1);

    // R11 same register on both sources
    cur_req = "R11";
    ins(5, 0, 0, 0, 0, 0, 0, 6, 1, 0); tick();
    ins(6, 6, 1, 0, 6, 1, 0, 0, 0, 0); tick();
    chk("R11", "double wait", 32'(ready_o[6]), 32'h0);
    cmp(6); tick(); tick();
    chk("R11", "both woken", 32'(ready_o[6]), 32'h1);

    // R5 untracked indices
    cur_req = "R7";
    sq_mask_i = 8'h7f; tick();
    chk("R7", "squash frees", 32'(busy_o), 32'h0);
    cur_req = "R5";
    ins(0, 20, 1, 0, 31, 1, 0, 25, 1, 0); tick();
    chk("R5", "untracked sources", 32'(ready_o[0]), 32'h1);
    cmp(20); tick(); tick();
    chk("R5", "preg unchanged", 32'(preg_rdy_o[10]), 32'h0);

    // R6 chain error
    cur_req = "R6";
    ins(1, 0, 0, 0, 0, 0, 0, 7, 1, 0); tick();
    ins(2, 7, 1, 0, 0, 0, 0, 0, 0, 0); tick();
    ins(3, 0, 0, 0, 0, 0, 0, 7, 1, 0);
    #1 chk("R6", "chain_err raised", 32'(chain_err_o), 32'h1);
    tick();
    cmp(7); tick();
    ins(4, 0, 0, 0, 0, 0, 0, 7, 1, 0);
    #1 chk("R6", "suppressed by applying completion", 32'(chain_err_o), 32'h0);
    cur_req = "R10";
    tick();
    chk("R10", "insert clear beats completion", 32'(preg_rdy_o[7]), 32'h0);
    chk("R6", "waiter woken", 32'(ready_o[2]), 32'h1);

    // R7 squash removes waiters
    cur_req = "R7";
    ins(5, 10, 1, 0, 0, 0, 0, 0, 0, 0); tick();
    sq_mask_i = 8'h20; tick();
    ins(6, 0, 0, 0, 0, 0, 0, 10, 1, 0);
    #1 chk("R7", "squashed not a waiter", 32'(chain_err_o), 32'h0);
    tick();
    ins(5, 7, 1, 0, 0, 0, 0, 0, 0, 0); tick();
    cmp(10); tick(); tick();
    chk("R7", "new occupant not woken", 32'(ready_o[5]), 32'h0);

    // R8 non-speculative block
    cur_req = "R8";
    ins(7, 0, 0, 0, 0, 0, 0, 0, 0, 1); tick();
    chk("R8", "busy", 32'(busy_o[7]), 32'h1);
    chk("R8", "blocked", 32'(ready_o[7]), 32'h0);
    nsr_valid_i = 1; nsr_slot_i = 3'd7; tick();
    chk("R8", "released", 32'(ready_o[7]), 32'h1);

    // R9 release
    cur_req = "R9";
    rel_valid_i = 1; rel_slot_i = 3'd7; tick();
    chk("R9", "slot freed", 32'(busy_o[7]), 32'h0);

    // R10 insert beats squash on same slot
    cur_req = "R10";
    sq_mask_i = 8'h04; ins(2, 0, 0, 0, 0, 0, 0, 0, 0, 0); tick();
    chk("R10", "insert wins busy", 32'(busy_o[2]), 32'h1);
    chk("R10", "insert wins ready", 32'(ready_o[2]), 32'h1);
    tick();

    done = 1;
    summary();
    $finish;
  end
endmodule